// File: doc/BRIEF.md
# Two-Way Storage Bus Register

This block sits between two data buses and carries words across in both directions at once. Each direction owns one storage word, one bit per data line, and four controls: an output enable (active low), a pass-through control, a capture strobe and an active-low strobe gate. Together these let the word act as a see-through path, a frozen value, an edge-loaded register or an edge-loaded register with a gate on the edge.

The design lives in a single system clock domain. The capture strobe is sampled on that clock, and a rising edge is detected in logic. Pass-through mode loads the input on every system clock, so the output follows the input one cycle later. For each direction the design drives a data bus and a drive-valid flag. A pad wrapper turns these into tri-state lines, floating the bus whenever the flag is low.

Top module: `ubr_transceiver`

## Requirements
- R1: While `rst` is high at a clock edge, both stored words and both drive-valid flags become zero after that edge.
- R2: When a direction's pass-through input is 1 at a clock edge, its output data after that edge equals the input data sampled at that edge. The strobe and the strobe gate have no effect in this case.
- R3: When pass-through is 0 and the strobe gate is 0 (open), a strobe rising edge captures the input data sampled at that clock edge. A rising edge is a clock edge where the strobe samples 1 and sampled 0 at the edge before.
- R4: When pass-through is 0 and the strobe samples the same level as at the edge before, whether held high or held low, the stored word does not change.
- R5: When pass-through is 0 and the strobe gate is 1 (closed), a strobe rising edge leaves the stored word unchanged.
- R6: The drive-valid flag after a clock edge is the inverse of the output enable sampled at that edge: 1 means the bus is driven, 0 means it floats.
- R7: The output enable has no effect on storage. Words still load, or hold, while the bus floats, and the data output shows them throughout.
- R8: When pass-through drops from 1 to 0 with no strobe capture, the word keeps the last value passed through.
- R9: The two directions are independent. No control or data input of one direction changes the other direction's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_din | input | 18 | Data from the A side |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B pass-through control |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_gate_n | input | 1 | A-to-B strobe gate, active low |
| ab_dout | output | 18 | Word presented to the B side |
| ab_drive | output | 1 | B side drive-valid flag |
| ba_din | input | 18 | Data from the B side |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A pass-through control |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_gate_n | input | 1 | B-to-A strobe gate, active low |
| ba_dout | output | 18 | Word presented to the A side |
| ba_drive | output | 1 | A side drive-valid flag |

## Verification
Directed sequences step one direction through pass-through, release to hold, a gated-open strobe rise, a strobe held high and then held low, and a gated-closed strobe rise. The input data changes on every step, so a load shows up as a new value and a hold shows up as the old one. Toggling the output enable while data is passed through tells a gated drive flag apart from gated storage. A final sweep runs all sixteen control combinations on one direction while the other direction gets a permuted set and different data, so any crosstalk between directions shows as a mismatch.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int unsigned DEF_WIDTH = 18;
  localparam int unsigned NUM_DIR   = 2;

  typedef struct packed {
    logic oe_n;
    logic pass;
    logic stb;
    logic stb_gate_n;
  } ubr_ctrl_t;
endpackage

// File: rtl/ubr_edge_det.sv
module ubr_edge_det (
  input  logic clk,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) level_q <= level;

  assign rise = level & ~level_q;
endmodule

// File: rtl/ubr_store.sv
module ubr_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pass,
  input  logic             rise,
  input  logic             gate_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic load;

  assign load = pass | (rise & ~gate_n);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));
  assert_pass_follow_R2: assert property (@(posedge clk) disable iff (rst)
    pass |=> (q == $past(d)));
  assert_edge_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!pass && rise && !gate_n) |=> (q == $past(d)));
  assert_steady_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!pass && !rise) |=> $stable(q));
  assert_gated_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!pass && gate_n) |=> $stable(q));
endmodule

// File: rtl/ubr_path.sv
module ubr_path
  import ubr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  ubr_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic rise;

  ubr_edge_det u_edge (
    .clk   (clk),
    .level (ctrl.stb),
    .rise  (rise)
  );

  ubr_store #(.WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .pass   (ctrl.pass),
    .rise   (rise),
    .gate_n (ctrl.stb_gate_n),
    .d      (din),
    .q      (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~ctrl.oe_n;
  end

  assert_drive_reset_R1: assert property (@(posedge clk) rst |=> !drive);
  assert_drive_on_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl.oe_n) |=> drive);
  assert_drive_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.oe_n) |=> !drive);
  assert_float_still_loads_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.oe_n && ctrl.pass) |=> (dout == $past(din)));
endmodule

// File: rtl/ubr_transceiver.sv
module ubr_transceiver
  import ubr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] ab_din,
  input  logic             ab_oe_n,
  input  logic             ab_pass,
  input  logic             ab_stb,
  input  logic             ab_stb_gate_n,
  output logic [WIDTH-1:0] ab_dout,
  output logic             ab_drive,
  input  logic [WIDTH-1:0] ba_din,
  input  logic             ba_oe_n,
  input  logic             ba_pass,
  input  logic             ba_stb,
  input  logic             ba_stb_gate_n,
  output logic [WIDTH-1:0] ba_dout,
  output logic             ba_drive
);
  ubr_ctrl_t        ctrl  [NUM_DIR];
  logic [WIDTH-1:0] din   [NUM_DIR];
  logic [WIDTH-1:0] dout  [NUM_DIR];
  logic             drive [NUM_DIR];

  assign ctrl[0] = '{oe_n: ab_oe_n, pass: ab_pass, stb: ab_stb, stb_gate_n: ab_stb_gate_n};
  assign ctrl[1] = '{oe_n: ba_oe_n, pass: ba_pass, stb: ba_stb, stb_gate_n: ba_stb_gate_n};
  assign din[0]  = ab_din;
  assign din[1]  = ba_din;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    ubr_path #(.WIDTH(WIDTH)) u_path (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl[g]),
      .din   (din[g]),
      .dout  (dout[g]),
      .drive (drive[g])
    );
  end

  assign ab_dout  = dout[0];
  assign ab_drive = drive[0];
  assign ba_dout  = dout[1];
  assign ba_drive = drive[1];

  // R9: the A-to-B outputs hold still while only B-to-A inputs could act
  assert_dir_isolation_R9: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_stb == $past(ab_stb) && ab_oe_n == $past(ab_oe_n))
      |=> ($stable(ab_dout) && $stable(ab_drive)));
endmodule

// File: tb/test_ubr_transceiver.sv
module test_ubr_transceiver;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] ab_din = '0, ba_din = '0;
  logic ab_oe_n = 1'b1, ab_pass = 1'b0, ab_stb = 1'b0, ab_stb_gate_n = 1'b1;
  logic ba_oe_n = 1'b1, ba_pass = 1'b0, ba_stb = 1'b0, ba_stb_gate_n = 1'b1;
  logic [W-1:0] ab_dout, ba_dout;
  logic ab_drive, ba_drive;

  always #4 clk = ~clk;

  ubr_transceiver #(.WIDTH(W)) i_ubr_transceiver (
    .clk(clk), .rst(rst),
    .ab_din(ab_din), .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_stb(ab_stb),
    .ab_stb_gate_n(ab_stb_gate_n), .ab_dout(ab_dout), .ab_drive(ab_drive),
    .ba_din(ba_din), .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_stb(ba_stb),
    .ba_stb_gate_n(ba_stb_gate_n), .ba_dout(ba_dout), .ba_drive(ba_drive)
  );

  // reference state built from the requirements
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_ab_en = 1'b0, m_ba_en = 1'b0;
  logic m_ab_prev = 1'b0, m_ba_prev = 1'b0;

  logic [2*W+1:0] exp_q[$];
  string          tag_q[$];
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic push(input string tag);
    if (rst) begin
      m_ab = '0; m_ba = '0; m_ab_en = 1'b0; m_ba_en = 1'b0;
    end else begin
      m_ab_en = ~ab_oe_n;
      m_ba_en = ~ba_oe_n;
      if (ab_pass || (ab_stb && !m_ab_prev && !ab_stb_gate_n)) m_ab = ab_din;
      if (ba_pass || (ba_stb && !m_ba_prev && !ba_stb_gate_n)) m_ba = ba_din;
    end
    m_ab_prev = ab_stb;
    m_ba_prev = ba_stb;
    exp_q.push_back({m_ab, m_ab_en, m_ba, m_ba_en});
    tag_q.push_back(tag);
  endtask

  task automatic step(input string tag);
    push(tag);
    @(negedge clk);
  endtask

  // monitor: compares one expected item per clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2*W+1:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {ab_dout, ab_drive, ba_dout, ba_drive};
      vectors++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual ab=%h/%b ba=%h/%b expected ab=%h/%b ba=%h/%b", t,
                 a[2*W+1:W+2], a[W+1], a[W:1], a[0],
                 e[2*W+1:W+2], e[W+1], e[W:1], e[0]);
      end
    end
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 1'b0;
    // pass-through on A-to-B, strobe and gate moving (R2)
    ab_oe_n = 1'b0; ab_pass = 1'b1; ab_din = 18'h12345; step("R2");
    ab_din = 18'h0abcd; ab_stb = 1'b1; ab_stb_gate_n = 1'b0; step("R2");
    ab_din = 18'h3ffff; ab_stb = 1'b0; ab_stb_gate_n = 1'b1; step("R2");
    // release pass-through: last value kept (R8)
    ab_pass = 1'b0; ab_din = 18'h00001; step("R8");
    ab_din = 18'h00002; step("R8");
    // open gate, strobe rise captures (R3)
    ab_stb_gate_n = 1'b0; ab_din = 18'h2aaaa; step("R4");
    ab_stb = 1'b1; ab_din = 18'h15555; step("R3");
    ab_din = 18'h0f0f0; step("R4");
    ab_stb = 1'b0; ab_din = 18'h30303; step("R4");
    ab_din = 18'h11111; step("R4");
    // closed gate: rise ignored (R5)
    ab_stb_gate_n = 1'b1; ab_stb = 1'b1; ab_din = 18'h22222; step("R5");
    ab_stb = 1'b0; step("R5");
    ab_stb = 1'b1; ab_din = 18'h33333; step("R5");
    // drive flag and loading while floating (R6, R7)
    ab_oe_n = 1'b1; step("R6");
    ab_pass = 1'b1; ab_din = 18'h04321; step("R7");
    ab_din = 18'h09876; step("R7");
    ab_pass = 1'b0; ab_stb = 1'b0; ab_stb_gate_n = 1'b0; step("R7");
    ab_stb = 1'b1; ab_din = 18'h1beef; step("R7");
    ab_oe_n = 1'b0; step("R6");
    // B-to-A alone, A quiet (R9)
    ab_stb = 1'b0; ba_oe_n = 1'b0; ba_pass = 1'b1; ba_din = 18'h2cafe; step("R9");
    ba_pass = 1'b0; ba_stb_gate_n = 1'b0; ba_stb = 1'b1; ba_din = 18'h01234; step("R9");
    ab_din = 18'h3dead; ba_stb = 1'b0; step("R9");
    // sweep of all control combinations, directions permuted (R9)
    for (int i = 0; i < 64; i++) begin
      ab_pass = i[0]; ab_stb = i[1]; ab_stb_gate_n = i[2]; ab_oe_n = i[3];
      ba_pass = i[3] ^ i[4]; ba_stb = i[0] ^ i[5]; ba_stb_gate_n = i[1]; ba_oe_n = i[2];
      ab_din = 18'(i * 4099 + 7);
      ba_din = 18'(~(i * 1031));
      step("R9");
    end
    // reset mid-run clears everything (R1)
    rst = 1'b1; step("R1");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule